// File: doc/BRIEF.md
# Multi-format minifloat decoder

This block turns one low-precision floating-point element code into the bit pattern of the same value in IEEE-754 single precision. A 32-bit format word arrives with each code and says how to read it. With bit 31 clear, the low bits hold a small id that picks one of seven fixed hardware formats. There are two 8-bit formats with the open conventions, two 8-bit formats in the "finite, unsigned zero" style, two 6-bit formats and one 4-bit format. Each fixed format applies its own special-value rules.

With bit 31 set, the word instead describes a generic all-finite minifloat. The word packs an exponent width, a mantissa width and a signed bias. The code's sign bit sits just above its exponent field. An exponent field of zero gives a subnormal.

Every value that any legal format can represent is exactly representable in single precision. No rounding is involved, so the decode is exact. A single output register, selected by a parameter, captures the result when the input is valid and holds it otherwise.

Top module: `mfd_top`

## Requirements
- R1: With descriptor bit 31 clear, the value in bits [30:0] selects the format: 0 = 8-bit e4m3 (bias 7), 1 = 8-bit e5m2 (bias 15), 2 = 8-bit e4m3 unsigned-zero (bias 8), 3 = 8-bit e5m2 unsigned-zero (bias 16), 4 = 6-bit e2m3 (bias 1), 5 = 6-bit e3m2 (bias 3), 6 = 4-bit e2m1 (bias 1). In format 0, codes 0x7F and 0xFF are NaN, and 0x7E decodes to 448 (0x43E00000).
- R2: In format 1, a code whose exponent field is all ones decodes to infinity of the code's sign when its mantissa is zero (0x7C gives 0x7F800000, 0xFC gives 0xFF800000) and to NaN otherwise. Code 0x7B decodes to 57344 (0x47600000).
- R3: In formats 2 and 3, code 0x80 is the only NaN and there is no infinity and no negative zero. Format 2 code 0x7F decodes to 240 (0x43700000). Format 3 code 0x7F decodes to the finite value 57344.
- R4: Formats 4, 5 and 6 have no special codes. Their largest codes decode to 7.5 (0x40F00000), 28 (0x41E00000) and 6 (0x40C00000) respectively.
- R5: With descriptor bit 31 set, bits [3:0] give the exponent width, bits [7:4] the mantissa width and bits [15:8] a two's-complement bias, and every code is finite. Descriptor 0x80000303 maps codes 1, 3 and 7 to 0.25, 1 and 16, and code 0xF to −16.
- R6: An exponent field of zero with a non-zero mantissa gives a subnormal, whose value is mantissa × 2^(1 − bias − mantissa width). Format 0 code 0x01 gives 2^−9 (0x3B000000), and generic e2m3 with bias 1 maps code 0x01 to 0.125 (0x3E000000).
- R7: A code with zero exponent and zero mantissa decodes to a zero carrying the code's sign bit, except in formats 2 and 3.
- R8: Code bits at or above the format's width (1 + exponent width + mantissa width) have no effect on the result.
- R9: The descriptor is illegal in three cases: an id above 6 with bit 31 clear, a generic exponent width of 0, or generic widths summing above 7. A generic bias that is negative or that exceeds 127 minus the mantissa width is also illegal. An illegal descriptor raises the error output and gives +0 (0x00000000).
- R10: Every NaN result is the quiet pattern with the code's sign: 0x7FC00000 or 0xFFC00000.
- R11: With the output register selected, `out_valid` follows `in_valid` one cycle later. `out_bits` and `out_err` update only on cycles where `in_valid` is high and otherwise hold. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Code and descriptor are valid this cycle |
| in_code | input | 8 | Element code, right-aligned |
| in_desc | input | 32 | Format descriptor word |
| out_valid | output | 1 | Result valid |
| out_bits | output | 32 | Single-precision bit pattern of the decoded value |
| out_err | output | 1 | Descriptor was illegal |

## Verification
With the default register stage, every result is due exactly one rising edge after the code and descriptor are presented. The reference model in the bench therefore keeps one cycle of expected state. That state includes the held value when `in_valid` is low. The bench drives on the falling edge and compares against the model on the next falling edge, so each result is sampled half a cycle after the edge that registered it. Directed cases use constants written into the requirements. Random cases use a behavioural integer model that builds each value as significand × 2^k and normalises it.

// File: rtl/mfd_pkg.sv
package mfd_pkg;

  localparam int CODE_W   = 8;
  localparam int DESC_W   = 32;
  localparam int FLD_W    = 4;
  localparam int BIAS_W   = 8;
  localparam int F32_W    = 32;
  localparam int F32_MAN  = 23;
  localparam int F32_EXP  = 8;
  localparam int F32_BIAS = 127;
  localparam int POS_W    = $clog2(CODE_W);
  localparam int NAMED_N  = 7;

  typedef enum logic [1:0] {
    RULE_PLAIN,
    RULE_OPEN_E4M3,
    RULE_OPEN_E5M2,
    RULE_UZERO
  } rule_e;

  typedef struct packed {
    logic [FLD_W-1:0]         ew;
    logic [FLD_W-1:0]         mw;
    logic signed [BIAS_W-1:0] bias;
    rule_e                    rule;
    logic                     bad;
  } fmt_t;

  function automatic fmt_t mk_fmt(input int ew, input int mw, input int bias, input rule_e rule);
    fmt_t f;
    f.ew   = FLD_W'(ew);
    f.mw   = FLD_W'(mw);
    f.bias = BIAS_W'(bias);
    f.rule = rule;
    f.bad  = 1'b0;
    return f;
  endfunction

endpackage

// File: rtl/mfd_fmt_sel.sv
module mfd_fmt_sel
  import mfd_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output fmt_t              fmt
);

  logic [8:0] bias_room;
  logic [4:0] width_sum;

  always_comb begin
    fmt       = mk_fmt(0, 0, 0, RULE_PLAIN);
    bias_room = {2'b00, desc[14:8]} + {5'b00000, desc[7:4]};
    width_sum = {1'b0, desc[3:0]} + {1'b0, desc[7:4]};
    if (desc[DESC_W-1]) begin
      fmt.ew   = desc[3:0];
      fmt.mw   = desc[7:4];
      fmt.bias = desc[15:8];
      fmt.rule = RULE_PLAIN;
      fmt.bad  = (desc[3:0] == 4'd0) || (width_sum > 5'(CODE_W-1)) ||
                 desc[15] || (bias_room > 9'd127);
    end else begin
      case (desc[DESC_W-2:0])
        31'd0:   fmt = mk_fmt(4, 3, 7,  RULE_OPEN_E4M3);
        31'd1:   fmt = mk_fmt(5, 2, 15, RULE_OPEN_E5M2);
        31'd2:   fmt = mk_fmt(4, 3, 8,  RULE_UZERO);
        31'd3:   fmt = mk_fmt(5, 2, 16, RULE_UZERO);
        31'd4:   fmt = mk_fmt(2, 3, 1,  RULE_PLAIN);
        31'd5:   fmt = mk_fmt(3, 2, 3,  RULE_PLAIN);
        31'd6:   fmt = mk_fmt(2, 1, 1,  RULE_PLAIN);
        default: fmt.bad = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/mfd_field_split.sv
module mfd_field_split
  import mfd_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  fmt_t              fmt,
  output logic              sign,
  output logic [CODE_W-1:0] expo,
  output logic [CODE_W-1:0] mant,
  output logic              expo_top,
  output logic              mant_full,
  output logic              sign_only
);

  logic [4:0]        sign_pos;
  logic [4:0]        width;
  logic [15:0]       code_mask;
  logic [15:0]       e_mask;
  logic [15:0]       m_mask;
  logic [CODE_W-1:0] c;
  logic [CODE_W-1:0] shifted;

  always_comb begin
    sign_pos  = {1'b0, fmt.ew} + {1'b0, fmt.mw};
    width     = sign_pos + 5'd1;
    code_mask = (16'd1 << width) - 16'd1;
    e_mask    = (16'd1 << fmt.ew) - 16'd1;
    m_mask    = (16'd1 << fmt.mw) - 16'd1;
    c         = code & code_mask[CODE_W-1:0];
    shifted   = c >> sign_pos;
    sign      = shifted[0];
    expo      = (c >> fmt.mw) & e_mask[CODE_W-1:0];
    mant      = c & m_mask[CODE_W-1:0];
    expo_top  = (expo == e_mask[CODE_W-1:0]);
    mant_full = (mant == m_mask[CODE_W-1:0]);
    sign_only = (c == {1'b1, {(CODE_W-1){1'b0}}});
  end

endmodule

// File: rtl/mfd_assemble.sv
module mfd_assemble
  import mfd_pkg::*;
(
  input  fmt_t              fmt,
  input  logic              sign,
  input  logic [CODE_W-1:0] expo,
  input  logic [CODE_W-1:0] mant,
  input  logic              expo_top,
  input  logic              mant_full,
  input  logic              sign_only,
  output logic [F32_W-1:0]  bits
);

  localparam logic [F32_EXP-1:0] EXP_ONES = '1;
  localparam logic [F32_MAN-1:0] QUIET    = {1'b1, {(F32_MAN-1){1'b0}}};

  logic [CODE_W-1:0]         sig;
  logic [POS_W-1:0]          pos;
  logic [CODE_W-1:0]         eff;
  logic signed [10:0]        bexp;
  logic [F32_MAN+CODE_W-1:0] frac_wide;
  logic [F32_W-1:0]          nan_w;
  logic [F32_W-1:0]          inf_w;

  always_comb begin
    sig = (expo != '0) ? ((CODE_W'(1) << fmt.mw) | mant) : mant;
    pos = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (sig[i]) pos = POS_W'(i);
    end
    eff  = (expo != '0) ? expo : CODE_W'(1);
    bexp = $signed({3'b000, eff})
         - $signed({{3{fmt.bias[BIAS_W-1]}}, fmt.bias})
         - $signed({7'b0000000, fmt.mw})
         + $signed({8'b00000000, pos})
         + 11'sd127;
    frac_wide = {{F32_MAN{1'b0}}, sig} << (5'(F32_MAN) - {2'b00, pos});
    nan_w = {sign, EXP_ONES, QUIET};
    inf_w = {sign, EXP_ONES, {F32_MAN{1'b0}}};

    if (fmt.bad)
      bits = '0;
    else if (fmt.rule == RULE_UZERO && sign_only)
      bits = nan_w;
    else if (fmt.rule == RULE_OPEN_E4M3 && expo_top && mant_full)
      bits = nan_w;
    else if (fmt.rule == RULE_OPEN_E5M2 && expo_top)
      bits = (mant == '0) ? inf_w : nan_w;
    else if (sig == '0)
      bits = {sign, {(F32_W-1){1'b0}}};
    else
      bits = {sign, bexp[F32_EXP-1:0], frac_wide[F32_MAN-1:0]};
  end

endmodule

// File: rtl/mfd_top.sv
module mfd_top
  import mfd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic [DESC_W-1:0] in_desc,
  output logic              out_valid,
  output logic [F32_W-1:0]  out_bits,
  output logic              out_err
);

  fmt_t              fmt;
  logic              f_sign;
  logic [CODE_W-1:0] f_expo;
  logic [CODE_W-1:0] f_mant;
  logic              f_expo_top;
  logic              f_mant_full;
  logic              f_sign_only;
  logic [F32_W-1:0]  dec_bits;

  mfd_fmt_sel u_sel (
    .desc (in_desc),
    .fmt  (fmt)
  );

  mfd_field_split u_split (
    .code      (in_code),
    .fmt       (fmt),
    .sign      (f_sign),
    .expo      (f_expo),
    .mant      (f_mant),
    .expo_top  (f_expo_top),
    .mant_full (f_mant_full),
    .sign_only (f_sign_only)
  );

  mfd_assemble u_asm (
    .fmt       (fmt),
    .sign      (f_sign),
    .expo      (f_expo),
    .mant      (f_mant),
    .expo_top  (f_expo_top),
    .mant_full (f_mant_full),
    .sign_only (f_sign_only),
    .bits      (dec_bits)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic             valid_q, valid_d;
      logic [F32_W-1:0] bits_q, bits_d;
      logic             err_q, err_d;

      always_comb begin
        valid_d = in_valid;
        bits_d  = bits_q;
        err_d   = err_q;
        if (in_valid) begin
          bits_d = dec_bits;
          err_d  = fmt.bad;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          bits_q  <= '0;
          err_q   <= 1'b0;
        end else begin
          valid_q <= valid_d;
          bits_q  <= bits_d;
          err_q   <= err_d;
        end
      end

      assign out_valid = valid_q;
      assign out_bits  = bits_q;
      assign out_err   = err_q;
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_bits  = dec_bits;
      assign out_err   = fmt.bad;
    end
  endgenerate

endmodule

// File: rtl/mfd_checker.sv
module mfd_checker #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  in_code,
  input logic [31:0] in_desc,
  input logic        out_valid,
  input logic [31:0] out_bits,
  input logic        out_err
);

  a_r9_err_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_bits == 32'h0));

  a_r10_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_bits[30:23] == 8'hFF && out_bits[22:0] != 23'h0) |-> (out_bits[22:0] == 23'h400000));

  generate
    if (REG_OUT) begin : g_seq
      a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

      a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

      a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_bits) && $stable(out_err)));

      a_r3_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_desc == 32'd2 || in_desc == 32'd3)) |=> (out_bits != 32'h80000000));

      a_r2_inf_only_open_e5m2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_desc != 32'd1) |=> (out_bits[30:0] != 31'h7F800000));

      a_r8_upper_bits_e2m1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_desc == 32'd6 && in_code[3:0] == 4'h7) |=> (out_bits == 32'h40C00000));
    end
  endgenerate

endmodule

bind mfd_top mfd_checker #(.REG_OUT(REG_OUT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_code   (in_code),
  .in_desc   (in_desc),
  .out_valid (out_valid),
  .out_bits  (out_bits),
  .out_err   (out_err)
);

// File: tb/mfd_top_tb_top.sv
module mfd_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_code;
  logic [31:0] in_desc;
  logic        out_valid;
  logic [31:0] out_bits;
  logic        out_err;

  int          n_checks;
  int          n_fails;
  logic        exp_valid;
  logic [31:0] exp_bits;
  logic        exp_err;
  string       exp_tag;
  bit          armed;

  mfd_top #(.REG_OUT(1'b1)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .in_desc   (in_desc),
    .out_valid (out_valid),
    .out_bits  (out_bits),
    .out_err   (out_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural model: value = significand * 2^k, then normalised.
  function automatic logic [32:0] ref_dec(input logic [7:0] code, input logic [31:0] desc);
    int ew, mw, bias, kind, width, c, s, e, m, sig, k, msb, fexp, frac;
    bit ok;
    ew = 0; mw = 0; bias = 0; kind = 0; ok = 1;
    if (desc[31]) begin
      ew   = int'(desc[3:0]);
      mw   = int'(desc[7:4]);
      bias = int'($signed(desc[15:8]));
      ok   = (ew >= 1) && (1 + ew + mw <= 8) && (bias >= 0) && (bias + mw <= 127);
    end else begin
      case (desc)
        32'd0: begin ew = 4; mw = 3; bias = 7;  kind = 1; end
        32'd1: begin ew = 5; mw = 2; bias = 15; kind = 2; end
        32'd2: begin ew = 4; mw = 3; bias = 8;  kind = 3; end
        32'd3: begin ew = 5; mw = 2; bias = 16; kind = 3; end
        32'd4: begin ew = 2; mw = 3; bias = 1; end
        32'd5: begin ew = 3; mw = 2; bias = 3; end
        32'd6: begin ew = 2; mw = 1; bias = 1; end
        default: ok = 0;
      endcase
    end
    if (!ok) return {1'b1, 32'h0};
    width = 1 + ew + mw;
    c = int'(code) % (1 << width);
    s = (c >> (ew + mw)) & 1;
    e = (c >> mw) % (1 << ew);
    m = c % (1 << mw);
    if (kind == 3 && c == 128) return {1'b0, 32'hFFC00000};
    if (kind == 1 && e == (1 << ew) - 1 && m == (1 << mw) - 1)
      return {1'b0, s[0], 31'h7FC00000};
    if (kind == 2 && e == (1 << ew) - 1)
      return (m == 0) ? {1'b0, s[0], 31'h7F800000} : {1'b0, s[0], 31'h7FC00000};
    if (e == 0) begin sig = m; k = 1 - bias - mw; end
    else begin sig = m + (1 << mw); k = e - bias - mw; end
    if (sig == 0) return {1'b0, s[0], 31'h0};
    msb = 0;
    while ((sig >> (msb + 1)) != 0) msb++;
    fexp = msb + k + 127;
    frac = (sig * (1 << (23 - msb))) - (1 << 23);
    return {1'b0, s[0], fexp[7:0], frac[22:0]};
  endfunction

  task automatic compare();
    n_checks++;
    if (out_valid !== exp_valid || out_bits !== exp_bits || out_err !== exp_err) begin
      n_fails++;
      $display("FAIL %s: got valid=%0b bits=%08h err=%0b, expected valid=%0b bits=%08h err=%0b",
               exp_tag, out_valid, out_bits, out_err, exp_valid, exp_bits, exp_err);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] c, input logic [31:0] d, input string tag,
                      input bit lit, input logic [31:0] lbits, input bit lerr);
    logic [32:0] r;
    @(negedge clk);
    if (armed) compare();
    in_valid = v;
    in_code  = c;
    in_desc  = d;
    exp_valid = v;
    exp_tag   = tag;
    if (v) begin
      r = lit ? {lerr, lbits} : ref_dec(c, d);
      exp_err  = r[32];
      exp_bits = r[31:0];
    end
    armed = 1'b1;
  endtask

  task automatic lit_ok(input logic [7:0] c, input logic [31:0] d, input string tag, input logic [31:0] b);
    step(1'b1, c, d, tag, 1'b1, b, 1'b0);
  endtask

  task automatic lit_bad(input logic [7:0] c, input logic [31:0] d, input string tag);
    step(1'b1, c, d, tag, 1'b1, 32'h0, 1'b1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL R11 watchdog: got run still active, expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fails = 0; armed = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_code = '0; in_desc = '0;
    exp_valid = 1'b0; exp_bits = '0; exp_err = 1'b0; exp_tag = "R11 reset state";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    armed = 1'b1;

    lit_ok(8'h38, 32'd0, "R1 e4m3 one", 32'h3F800000);
    lit_ok(8'h7E, 32'd0, "R1 e4m3 max 448", 32'h43E00000);
    lit_ok(8'h7F, 32'd0, "R1 e4m3 NaN pos", 32'h7FC00000);
    lit_ok(8'hFF, 32'd0, "R10 e4m3 NaN neg", 32'hFFC00000);
    lit_ok(8'h7C, 32'd1, "R2 e5m2 +inf", 32'h7F800000);
    lit_ok(8'hFC, 32'd1, "R2 e5m2 -inf", 32'hFF800000);
    lit_ok(8'h7D, 32'd1, "R2 e5m2 NaN", 32'h7FC00000);
    lit_ok(8'h7B, 32'd1, "R2 e5m2 max", 32'h47600000);
    lit_ok(8'h80, 32'd2, "R3 uzero e4m3 NaN", 32'hFFC00000);
    lit_ok(8'h7F, 32'd2, "R3 uzero e4m3 max 240", 32'h43700000);
    lit_ok(8'h7F, 32'd3, "R3 uzero e5m2 finite max", 32'h47600000);
    lit_ok(8'h80, 32'd3, "R3 uzero e5m2 NaN", 32'hFFC00000);
    lit_ok(8'h00, 32'd2, "R3 uzero zero", 32'h00000000);
    lit_ok(8'h1F, 32'd4, "R4 e2m3 max", 32'h40F00000);
    lit_ok(8'h3F, 32'd4, "R4 e2m3 min", 32'hC0F00000);
    lit_ok(8'h1F, 32'd5, "R4 e3m2 max", 32'h41E00000);
    lit_ok(8'h07, 32'd6, "R4 e2m1 max", 32'h40C00000);
    lit_ok(8'h01, 32'd6, "R6 e2m1 subnormal", 32'h3F000000);
    lit_ok(8'h01, 32'h80000303, "R5 generic 0.25", 32'h3E800000);
    lit_ok(8'h03, 32'h80000303, "R5 generic 1", 32'h3F800000);
    lit_ok(8'h07, 32'h80000303, "R5 generic 16", 32'h41800000);
    lit_ok(8'h0F, 32'h80000303, "R5 generic -16", 32'hC1800000);
    lit_ok(8'h01, 32'd0, "R6 e4m3 subnormal", 32'h3B000000);
    lit_ok(8'h01, 32'h80000132, "R6 generic subnormal", 32'h3E000000);
    lit_ok(8'h80, 32'd0, "R7 e4m3 neg zero", 32'h80000000);
    lit_ok(8'h08, 32'h80000303, "R7 generic neg zero", 32'h80000000);
    lit_ok(8'hF7, 32'd6, "R8 e2m1 upper bits", 32'h40C00000);
    lit_ok(8'h5F, 32'd4, "R8 e2m3 upper bits", 32'h40F00000);
    lit_ok(8'hF3, 32'h80000303, "R8 generic upper bits", 32'h3F800000);
    lit_bad(8'h11, 32'h80000000, "R9 zero exponent width");
    lit_bad(8'h11, 32'h80000053, "R9 width over 8");
    lit_bad(8'h11, 32'd7, "R9 unknown id");
    lit_bad(8'h11, 32'h8000FF13, "R9 negative bias");
    lit_bad(8'h11, 32'h80007F23, "R9 bias too large");
    lit_ok(8'h7E, 32'd0, "R11 load before idle", 32'h43E00000);
    step(1'b0, 8'h01, 32'd4, "R11 idle holds", 1'b0, 32'h0, 1'b0);
    step(1'b0, 8'hFF, 32'h80000000, "R11 idle holds", 1'b0, 32'h0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      bit v;
      v = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 1) == 0)
        d = 32'($urandom_range(0, 7));
      else begin
        d = {1'b1, 15'h0, 8'($urandom_range(0, 20)), 4'($urandom_range(0, 7)), 4'($urandom_range(0, 8))};
        if ($urandom_range(0, 9) == 0) d[15:8] = 8'($urandom);
      end
      step(v, 8'($urandom), d, d[31] ? "R5/R6/R9 random generic" : "R1/R2/R3/R4 random named",
           1'b0, 32'h0, 1'b0);
    end

    @(negedge clk);
    compare();
    finish_run();
  end

endmodule